// File: doc/BRIEF.md
# Two-Read Register File with Replicated Storage

This block is a small register file of 32 entries, each 32 bits wide, with one write port and two read ports that work independently. It is meant for the operand-fetch stage of a small pipelined datapath, where two source operands are read in the same cycle that an earlier instruction writes its result back.

Each read port has its own copy of the storage. A write goes into both copies at the same address in the same cycle. Each read port reads only its own copy, so each copy is a plain one-write, one-read memory with a registered read, of the kind an FPGA block RAM can implement. A read returns data one clock after its address is presented. A write that targets the address being read in the same cycle is forwarded, so a read never returns a value that is one write stale.

The memory copies have no reset. Instead, after a synchronous reset a clear sequencer writes zero into every entry of both copies, one entry per cycle. While it runs, a busy output is high, external writes are dropped, and both read outputs are held at zero.

Top module: `rf_dual_read`

## Requirements
- R1: While `rst` is high, `busy` is high. After `rst` falls, `busy` stays high for exactly 32 more rising edges and then goes low. It stays low until the next reset.
- R2: After a clear sequence completes, every one of the 32 entries reads as zero on both ports, including entries that held other data before the reset.
- R3: A write requested while `busy` is high is ignored. Once the clear has finished, the target entry still reads zero.
- R4: Both read outputs are zero during reset and in the clock that follows any cycle in which `busy` was high.
- R5: When no write to the same address happens in the same cycle, read port 0 returns the last value written to `rd0_addr`, one clock after the address is presented.
- R6: Read port 1 behaves like R5 for `rd1_addr`, independently of port 0. The two ports may present different addresses or the same address in the same cycle.
- R7: If `wr_en` is high and `wr_addr` equals `rd0_addr` in a cycle, port 0 returns `wr_data` from that cycle one clock later.
- R8: The forwarding rule of R7 applies to port 1 on its own compare. Both ports can forward in the same cycle, and either one can forward while the other does not.
- R9: A cycle with `wr_en` low changes no entry, even when `wr_addr` and `wr_data` are driven.
- R10: When the same entry is written in two consecutive cycles, the second value is the one that is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; starts the clear sequence |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd0_addr | input | 5 | Read address of port 0 |
| rd1_addr | input | 5 | Read address of port 1 |
| rd0_data | output | 32 | Read data of port 0, one clock after its address |
| rd1_data | output | 32 | Read data of port 1, one clock after its address |
| busy | output | 1 | High while the clear sequence owns the memories |

## Verification
The two copies are written only through a shared path. A write that reached one copy but not the other would show up as a mismatch between the ports the first time both read that entry. A clear counter that skips or repeats an address leaves a nonzero entry behind. The post-reset sweep reads every address, so it exposes this within 32 cycles of `busy` falling. A wrong forwarding compare or a misaligned read register shows up one clock after the colliding cycle, as the stale or neighbouring value. The collision patterns in the vector table and the random traffic catch this on either port.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Source selected for a read output in the cycle after the address
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_BANK = 2'd1,
    SRC_FWD  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rf_clear_seq.sv
module rf_clear_seq #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [AW-1:0] clr_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy <= 1'b0;
    end
  end

  assign clr_addr = cnt_q;

  // R1: busy drops only after the final entry was cleared
  a_r1_clear_ends_at_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt_q) == LAST);

  // R2: the clear walks addresses one by one without skipping
  a_r2_clear_steps: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DEPTH = 32,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  // One write, one registered read: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] bank_q,
  output logic [DW-1:0] rdata
);
  rd_src_e       src_q;
  logic [DW-1:0] fwd_q;

  always_ff @(posedge clk) begin
    if (rst)                               src_q <= SRC_ZERO;
    else if (busy)                         src_q <= SRC_ZERO;
    else if (wr_en && (waddr == raddr))    src_q <= SRC_FWD;
    else                                   src_q <= SRC_BANK;
    fwd_q <= wdata;
  end

  always_comb begin
    case (src_q)
      SRC_BANK: rdata = bank_q;
      SRC_FWD:  rdata = fwd_q;
      default:  rdata = '0;
    endcase
  end

  // R7: a colliding write is returned on the following clock
  a_r7_forward_hit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && waddr == raddr) |=> rdata == $past(wdata));

  // R4: output is zero after any busy cycle
  a_r4_zero_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> rdata == '0);
endmodule

// File: rtl/rf_dual_read.sv
module rf_dual_read #(
  parameter int DEPTH = 32,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int NRD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd0_addr,
  input  logic [AW-1:0] rd1_addr,
  output logic [DW-1:0] rd0_data,
  output logic [DW-1:0] rd1_data,
  output logic          busy
);
  logic [AW-1:0] clr_addr;
  logic          ext_we;
  logic          bank_we;
  logic [AW-1:0] bank_wa;
  logic [DW-1:0] bank_wd;
  logic [AW-1:0] ra [NRD];
  logic [DW-1:0] rd [NRD];

  rf_clear_seq #(.DEPTH(DEPTH)) u_clear (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .clr_addr (clr_addr)
  );

  // The sequencer owns the shared write path while busy
  assign ext_we  = wr_en && !busy;
  assign bank_we = busy || wr_en;
  assign bank_wa = busy ? clr_addr : wr_addr;
  assign bank_wd = busy ? '0 : wr_data;

  assign ra[0]    = rd0_addr;
  assign ra[1]    = rd1_addr;
  assign rd0_data = rd[0];
  assign rd1_data = rd[1];

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [DW-1:0] bank_q;

    rf_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
      .clk     (clk),
      .we      (bank_we),
      .waddr   (bank_wa),
      .wdata   (bank_wd),
      .raddr   (ra[p]),
      .rdata_q (bank_q)
    );

    rf_rd_port #(.DEPTH(DEPTH), .DW(DW)) u_rd (
      .clk    (clk),
      .rst    (rst),
      .busy   (busy),
      .wr_en  (ext_we),
      .waddr  (wr_addr),
      .wdata  (wr_data),
      .raddr  (ra[p]),
      .bank_q (bank_q),
      .rdata  (rd[p])
    );
  end

  // R1: once the clear is done, busy never returns without reset
  a_r1_busy_stays_low: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  // R8: port 1 forwards on its own compare
  a_r8_forward_port1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && wr_addr == rd1_addr) |=> rd1_data == $past(wr_data));
endmodule

// File: tb/tb_rf_dual_read.sv
`timescale 1ns/1ps
module tb_rf_dual_read;
  localparam int DEPTH = 32;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int VW = 1 + AW + DW + AW + AW;
  localparam int NV = 12;

  // {wr_en, wr_addr, wr_data, rd0_addr, rd1_addr}; expected data comes from the model
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 5'd3,  32'hA5A5_0003, 5'd0,  5'd1 },  // R5 plain write
    {1'b1, 5'd7,  32'h1234_5678, 5'd3,  5'd3 },  // R5 R6 same address both ports
    {1'b1, 5'd9,  32'hDEAD_BEEF, 5'd9,  5'd7 },  // R7 port 0 forwards, R6 port 1 reads
    {1'b1, 5'd11, 32'hCAFE_0011, 5'd3,  5'd11},  // R8 port 1 forwards alone
    {1'b1, 5'd20, 32'h0BAD_F00D, 5'd20, 5'd20},  // R7 R8 both forward
    {1'b0, 5'd3,  32'hFFFF_FFFF, 5'd3,  5'd3 },  // R9 disabled write, no forward
    {1'b1, 5'd31, 32'h8000_0001, 5'd0,  5'd31},  // R8 top entry
    {1'b1, 5'd31, 32'h7FFF_FFFE, 5'd31, 5'd31},  // R10 overwrite, forwarded
    {1'b0, 5'd31, 32'h0000_0000, 5'd31, 5'd20},  // R10 second value kept
    {1'b1, 5'd0,  32'h0000_00FF, 5'd9,  5'd0 },  // R8 entry 0
    {1'b0, 5'd0,  32'h1111_1111, 5'd0,  5'd11},  // R9 entry 0 keeps value
    {1'b1, 5'd5,  32'h5555_AAAA, 5'd3,  5'd9 }   // R6 distinct reads
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd0_addr;
  logic [AW-1:0] rd1_addr;
  logic [DW-1:0] rd0_data;
  logic [DW-1:0] rd1_data;
  logic          busy;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  rf_dual_read #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd1_addr(rd1_addr),
    .rd0_data(rd0_data), .rd1_data(rd1_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Called at a falling edge: drive one cycle, advance one clock, check the reads
  task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     input logic [AW-1:0] a0, input logic [AW-1:0] a1);
    logic [DW-1:0] e0, e1;
    string t0, t1;
    wr_en = we; wr_addr = wa; wr_data = wd; rd0_addr = a0; rd1_addr = a1;
    e0 = (we && wa == a0) ? wd : model[a0];
    e1 = (we && wa == a1) ? wd : model[a1];
    t0 = (we && wa == a0) ? "R7 port0 forward" : "R5 port0 read";
    t1 = (we && wa == a1) ? "R8 port1 forward" : "R6 port1 read";
    if (we) model[wa] = wd;
    @(negedge clk);
    chk(t0, rd0_data, e0);
    chk(t1, rd1_data, e1);
  endtask

  task automatic do_reset_and_clear();
    int k;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd0_addr = '0; rd1_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd1);
    chk("R4 port0 zero in reset", rd0_data, '0);
    chk("R4 port1 zero in reset", rd1_data, '0);
    rst = 1'b0;
    // Writes attempted during the clear must be dropped (R3)
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hBADC_0DE5; rd0_addr = 5'd5; rd1_addr = 5'd5;
    k = 0;
    while (busy && k < 40) begin
      @(negedge clk);
      k++;
      wr_addr = AW'(k);
      rd0_addr = AW'(k);
      rd1_addr = 5'd5;
      if (k <= 32) begin
        chk("R4 port0 zero while clearing", rd0_data, '0);
        chk("R4 port1 zero while clearing", rd1_data, '0);
      end
    end
    chk("R1 busy length after reset", 32'(k), 32'd32);
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset_and_clear();

    // R3: the write attempted during the clear left entry 5 at zero
    cyc(1'b0, 5'd0, '0, 5'd5, 5'd5);
    chk("R3 entry5 after busy write", rd0_data, '0);

    // R2: sweep every entry on both ports
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, 5'd0, '0, AW'(i), AW'(DEPTH - 1 - i));
      chk("R2 cleared entry", rd0_data | rd1_data, '0);
    end

    // Vector table
    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][VW-1], VEC[v][VW-2 -: AW], VEC[v][2*AW +: DW],
          VEC[v][AW +: AW], VEC[v][0 +: AW]);
    end

    // R9: disabled writes over a filled entry
    cyc(1'b1, 5'd14, 32'h0000_1414, 5'd0, 5'd0);
    cyc(1'b0, 5'd14, 32'hFFFF_0000, 5'd14, 5'd14);
    chk("R9 entry14 unchanged", rd1_data, 32'h0000_1414);

    // R10: back-to-back writes to one entry, read afterwards
    cyc(1'b1, 5'd17, 32'h0000_0001, 5'd1, 5'd2);
    cyc(1'b1, 5'd17, 32'h0000_0002, 5'd1, 5'd2);
    cyc(1'b0, 5'd0, '0, 5'd17, 5'd17);
    chk("R10 last write kept", rd0_data, 32'h0000_0002);

    // Random traffic with a small address range to raise collision odds
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] wa;
      wa = (i % 3 == 0) ? AW'($urandom_range(0, 3)) : AW'($urandom);
      cyc(1'($urandom), wa, DW'($urandom),
          (i % 4 == 0) ? wa : AW'($urandom),
          (i % 5 == 0) ? wa : AW'($urandom));
    end

    // R2 again: a second reset clears data written above
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, AW'(i), 32'hF0F0_0000 | 32'(i), 5'd0, 5'd0);
    do_reset_and_clear();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, 5'd0, '0, AW'(i), AW'(i));
      chk("R2 cleared after second reset", rd0_data | rd1_data, '0);
    end
    chk("R1 busy stays low", {31'd0, busy}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule